// File: doc/BRIEF.md
# Double-Buffered Field Base Address Registers

This block is a small register bank inside a video capture engine. It holds two memory base addresses: one for even fields and one for odd fields. Software programs them through a plain memory-mapped write port and reads them back through a combinational read port.

A software write never changes an address that the capture path is using. The write goes into a shadow copy and raises a sticky "update pending" flag. When the capture datapath signals the first data beat of a new field, every shadow that was written since the last commit moves into its active register in the same cycle, and the flag clears. On that same strobe the block also latches the base address for the starting field, chosen by a parity input, so the address generator sees one value for the whole field.

Top module: `fbase_regbank`

## Requirements
- R1: After reset, both active base addresses, the field base output and the pending flag are zero. Reads at offsets 18h, 1Ch and 08h return 0.
- R2: Bits [4:0] of a written value are forced to zero. An active base address and its readback therefore always have bits [4:0] equal to 0.
- R3: A write to offset 18h (even) or 1Ch (odd) does not change the active value. A read of that offset, and the matching base output, keep the old value until the next field start.
- R4: A write to 18h or 1Ch sets the pending flag. A read of offset 08h returns the flag in bit 16 and 0 in every other bit. Offset 08h cannot be written.
- R5: In the cycle after a field-start strobe, every written shadow is active, and the pending flag is clear if no write came with the strobe.
- R6: At a commit, a register that was not written since the previous commit keeps its active value.
- R7: When a write and the field-start strobe fall in the same cycle, the older pending value is committed. The new value stays pending and the flag stays set until the next strobe.
- R8: On a field-start strobe the field base output takes the newly active odd base if the parity input is 1, or the even base if it is 0. It holds that value until the next strobe.
- R9: A write to any offset other than 18h and 1Ch has no effect. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| field_start | input | 1 | First data beat of a new field |
| field_odd | input | 1 | Parity of the starting field (1 = odd) |
| even_base | output | 32 | Active even-field base address |
| odd_base | output | 32 | Active odd-field base address |
| field_base | output | 32 | Base address latched for the current field |
| update_pending | output | 1 | A written value is waiting for the next field |

## Verification
The bench uses the default parameters: 32-bit data, five alignment bits, status bit 16, and slots at 18h and 1Ch with a 4-byte stride. With these values, writes with low bits set show the alignment masking. Both slots can be written alone or together, so a partial commit can be told apart from a full one. Driving the write and the strobe in the same cycle makes the collision ordering visible at the ports.

// File: rtl/fbase_pkg.sv
package fbase_pkg;
   localparam int unsigned FB_NUM_SLOTS = 2;   // even, odd
   localparam int unsigned FB_SLOT_EVEN = 0;
   localparam int unsigned FB_SLOT_ODD  = 1;
endpackage

// File: rtl/fbase_slot.sv
module fbase_slot #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ALIGN_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   output logic [DATA_W-1:0] active,
   output logic [DATA_W-1:0] active_nxt,
   output logic              dirty
);
   localparam logic [DATA_W-1:0] KEEP_MASK = {DATA_W{1'b1}} << ALIGN_BITS;

   logic [DATA_W-1:0] shadow;
   logic [DATA_W-1:0] wr_aligned;

   assign wr_aligned = wr_data & KEEP_MASK;
   assign active_nxt = (commit && dirty) ? shadow : active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= '0;
         shadow <= '0;
         dirty  <= 1'b0;
      end else begin
         active <= active_nxt;
         if (wr_hit) begin
            shadow <= wr_aligned;
            dirty  <= 1'b1;
         end else if (commit) begin
            dirty  <= 1'b0;
         end
      end
   end

   // R3: the active copy only moves on a field start
   assert_active_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active));
   // R2: alignment bits of the active copy stay clear
   assert_active_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active[ALIGN_BITS-1:0] == '0);
   // R7: a write always leaves something pending
   assert_write_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> dirty);
   // R6: an untouched slot survives a commit
   assert_clean_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !dirty) |=> $stable(active));
endmodule

// File: rtl/fbase_regbank.sv
module fbase_regbank #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned OFS_W      = 8,
   parameter int unsigned ALIGN_BITS = 5,
   parameter int unsigned STATUS_BIT = 16,
   parameter int unsigned STAT_OFS   = 'h08,
   parameter int unsigned SLOT_BASE  = 'h18,
   parameter int unsigned SLOT_STEP  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [OFS_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              field_start,
   input  logic              field_odd,
   output logic [DATA_W-1:0] even_base,
   output logic [DATA_W-1:0] odd_base,
   output logic [DATA_W-1:0] field_base,
   output logic              update_pending
);
   import fbase_pkg::*;

   localparam int unsigned NSLOT = FB_NUM_SLOTS;

   generate
      if (ALIGN_BITS == 0 || ALIGN_BITS >= DATA_W)
         $error("ALIGN_BITS must be within 1..DATA_W-1");
      if (STATUS_BIT >= DATA_W)
         $error("STATUS_BIT must fall inside the data word");
      if (SLOT_BASE + NSLOT * SLOT_STEP > (1 << OFS_W))
         $error("slot offsets exceed the offset width");
   endgenerate

   logic [NSLOT-1:0][DATA_W-1:0] act;
   logic [NSLOT-1:0][DATA_W-1:0] act_nxt;
   logic [NSLOT-1:0]             dirty;
   logic [NSLOT-1:0]             hit;

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      localparam logic [OFS_W-1:0] MY_OFS = OFS_W'(SLOT_BASE + g * SLOT_STEP);
      assign hit[g] = wr_en && (wr_addr == MY_OFS);
      fbase_slot #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) slot_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_hit     (hit[g]),
         .wr_data    (wr_data),
         .commit     (field_start),
         .active     (act[g]),
         .active_nxt (act_nxt[g]),
         .dirty      (dirty[g])
      );
   end

   assign even_base      = act[FB_SLOT_EVEN];
   assign odd_base       = act[FB_SLOT_ODD];
   assign update_pending = |dirty;

   always_ff @(posedge clk) begin
      if (!rst_n)
         field_base <= '0;
      else if (field_start)
         field_base <= field_odd ? act_nxt[FB_SLOT_ODD] : act_nxt[FB_SLOT_EVEN];
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == OFS_W'(STAT_OFS))
         rd_data[STATUS_BIT] = update_pending;
      for (int i = 0; i < NSLOT; i++)
         if (rd_addr == OFS_W'(SLOT_BASE + i * SLOT_STEP))
            rd_data = act[i];
   end

   // R8: the field base follows parity onto the freshly committed values
   assert_field_pick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> field_base == ($past(field_odd) ? odd_base : even_base));
   // R8: held between strobes
   assert_field_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start |=> $stable(field_base));
   // R5: a strobe with no write clears the flag
   assert_flag_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (field_start && !(|hit)) |=> !update_pending);
   // R4: any base write raises the flag
   assert_flag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> update_pending);
endmodule

// File: tb/fbase_regbank_tb.sv
module fbase_regbank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        field_start = 1'b0;
   logic        field_odd = 1'b0;
   logic [31:0] even_base, odd_base, field_base;
   logic        update_pending;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   fbase_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .field_start(field_start), .field_odd(field_odd),
      .even_base(even_base), .odd_base(odd_base),
      .field_base(field_base), .update_pending(update_pending)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic strobe(input logic odd);
      @(negedge clk);
      field_start = 1'b1; field_odd = odd;
      @(negedge clk);
      field_start = 1'b0;
   endtask

   task automatic t_reset;
      rd_chk("R1 even read", 8'h18, 32'h0);
      rd_chk("R1 odd read", 8'h1C, 32'h0);
      rd_chk("R1 status read", 8'h08, 32'h0);
      chk("R1 field_base", field_base, 32'h0);
   endtask

   task automatic t_single_even;
      wr(8'h18, 32'h1234_567F);
      rd_chk("R3 even read before field", 8'h18, 32'h0);
      chk("R3 even_base before field", even_base, 32'h0);
      rd_chk("R4 status bit 16", 8'h08, 32'h0001_0000);
      strobe(1'b0);
      rd_chk("R2 R5 even committed masked", 8'h18, 32'h1234_5660);
      rd_chk("R5 status cleared", 8'h08, 32'h0);
      chk("R6 odd untouched", odd_base, 32'h0);
      chk("R8 even selected", field_base, 32'h1234_5660);
   endtask

   task automatic t_both_odd;
      wr(8'h1C, 32'hAAAA_BBBF);
      wr(8'h18, 32'h0000_1000);
      strobe(1'b1);
      chk("R5 odd committed", odd_base, 32'hAAAA_BBA0);
      chk("R5 even committed", even_base, 32'h0000_1000);
      chk("R8 odd selected", field_base, 32'hAAAA_BBA0);
   endtask

   task automatic t_hold;
      wr(8'h1C, 32'h5000_0000);
      repeat (3) @(negedge clk);
      chk("R8 field_base held", field_base, 32'hAAAA_BBA0);
      chk("R3 odd_base held", odd_base, 32'hAAAA_BBA0);
   endtask

   task automatic t_collide;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h1C; wr_data = 32'h6000_0000;
      field_start = 1'b1; field_odd = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; field_start = 1'b0;
      chk("R7 older value committed", odd_base, 32'h5000_0000);
      chk("R7 flag kept", {31'b0, update_pending}, 32'h1);
      chk("R7 R8 field base old value", field_base, 32'h5000_0000);
      strobe(1'b0);
      chk("R7 newer value committed", odd_base, 32'h6000_0000);
      chk("R7 flag cleared", {31'b0, update_pending}, 32'h0);
      chk("R8 back to even", field_base, 32'h0000_1000);
   endtask

   task automatic t_other;
      wr(8'h08, 32'hFFFF_FFFF);
      rd_chk("R4 R9 status not writable", 8'h08, 32'h0);
      wr(8'h40, 32'hFFFF_FFE0);
      rd_chk("R9 unmapped read", 8'h40, 32'h0);
      rd_chk("R9 even unchanged", 8'h18, 32'h0000_1000);
      rd_chk("R9 odd unchanged", 8'h1C, 32'h6000_0000);
      chk("R9 no pending", {31'b0, update_pending}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_even();
      t_both_odd();
      t_hold();
      t_collide();
      t_other();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule